// File: doc/BRIEF.md
# USB Device Register Bank

This block is the register file that firmware uses to control the device side of a USB full-speed/low-speed core. A byte-wide bus with cycle and strobe qualifiers reaches the registers. The block holds five kinds of register: a global control word that selects the role and carries a soft-reset command, a device control byte, the device address, one control register per endpoint, and an interrupt status register with a mask. The block drives the endpoint flags, the device address, the role and a single interrupt line to the rest of the core.

A packet engine sends event inputs into the bank. These are a transaction-done pulse with its endpoint number, a bus-reset pulse, the VBUS level and the two-bit connect state. When a transaction on an endpoint completes, the hardware drops that endpoint's ready flag. The bank samples the VBUS and connect levels on every clock and raises a status bit whenever a level changes. Firmware clears status bits by writing ones to them.

The bus map is as follows. Offset 0 holds the global control word, 1 the device control byte, 2 the device address, 3 the interrupt status, 4 the interrupt mask, 5 the line status, and 8+n the control register of endpoint n.

Top module: `usbd_regbank`

## Requirements
- R1: After hardware reset, every register reads 0x00 except the interrupt mask, which reads 0xFF. The interrupt line, the endpoint flags, the role output and the address output are all low.
- R2: The device control byte (offset 1), the device address (offset 2), the mask (offset 4) and bit 0 of the global word (offset 0) read back the value last written. The address and role outputs follow the stored values.
- R3: Writing 1 to bit 1 of the global word starts a soft reset. One clock later the bank clears every register, bit 1 included, and sets the mask back to 0xFF. A read after that returns 0x00 from the global word.
- R4: In the endpoint register at offset 8+n, bit 0 is enable and bit 1 is ready. Writing 0x03 arms endpoint n, and the per-endpoint enable and ready outputs follow bits 0 and 1.
- R5: A transaction-done pulse for endpoint n clears only that endpoint's ready bit. Its enable bit stays set, so the register then reads 0x01, and the other endpoints are not affected.
- R6: Interrupt status (offset 3) has three bits. Bit 0 is set by a transaction-done pulse. Bit 2 is set by a bus-reset pulse or by a change of the connect state. Bit 5 is set by a change of VBUS. A level change means the input differs from the value sampled at the previous clock edge.
- R7: Writing 1 to a status bit clears that bit, and bits written 0 are left as they are. Writing back a value just read returns the register to 0x00.
- R8: When a status bit is set by an event and cleared by a write in the same cycle, the event wins and the bit ends up set.
- R9: Line status (offset 5) is read-only. It reports VBUS in bit 2 and the connect state in bits [1:0], as sampled at the last clock edge. A full-speed connection with VBUS present reads 0x06, and a disconnect with VBUS present reads 0x04.
- R10: The interrupt line is high exactly when some status bit is set and its mask bit is also set.
- R11: The acknowledge is high in every cycle where both cycle and strobe are high. A write takes effect at the clock edge that ends the acknowledged cycle, and read data is valid during that same cycle.
- R12: When software writes an endpoint register in the same cycle as a transaction-done pulse for that endpoint, the written value wins.

Ports are listed in the order of the top module's port list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cyc_i | input | 1 | Bus cycle valid |
| stb_i | input | 1 | Bus strobe |
| we_i | input | 1 | Write enable |
| adr_i | input | ADR_W | Register offset |
| dat_i | input | 8 | Write data |
| dat_o | output | 8 | Read data |
| ack_o | output | 1 | Bus acknowledge |
| txn_done_i | input | 1 | Transaction-complete pulse |
| txn_ep_i | input | EP_W | Endpoint of the completed transaction |
| bus_reset_i | input | 1 | Bus-reset detected pulse |
| vbus_i | input | 1 | VBUS present level |
| conn_state_i | input | 2 | Connect state (0 disconnected, 2 full speed) |
| ep_enable_o | output | NUM_EP | Endpoint enable flags |
| ep_ready_o | output | NUM_EP | Endpoint ready flags |
| dev_addr_o | output | 8 | Device address |
| dev_ctrl_o | output | 8 | Device control byte |
| host_mode_o | output | 1 | Role select (1 host, 0 device) |
| irq_o | output | 1 | Interrupt request |

## Verification
Two kinds of collision can happen in one cycle: a hardware event and a software write that target the same bit. The bench provokes the first by driving a write-one-to-clear of status 0x05 and a transaction-done pulse in the same cycle, while bit 2 is already set. The expected result is 0x01: bit 2 is cleared and bit 0 is set, because the event wins. For the second, the bench arms an endpoint in the same cycle that its done pulse arrives. The read-back must be 0x03, which shows that the write won over the hardware clear.

// File: rtl/usbd_regs_pkg.sv
`timescale 1ns/1ps
package usbd_regs_pkg;
  localparam int DW = 8;

  localparam int OFS_GLOBAL = 0;
  localparam int OFS_DEVCTL = 1;
  localparam int OFS_DEVADR = 2;
  localparam int OFS_ISTAT  = 3;
  localparam int OFS_IMASK  = 4;
  localparam int OFS_LINE   = 5;
  localparam int OFS_EP0    = 8;

  localparam int BIT_DONE = 0;
  localparam int BIT_CONN = 2;
  localparam int BIT_VBUS = 5;

  localparam int GLB_ROLE = 0;
  localparam int GLB_SOFT = 1;

  localparam logic [DW-1:0] MASK_RESET = 8'hFF;

  // The next status word. An event sets a bit and takes priority over a
  // software clear; a wipe overrides both.
  function automatic logic [DW-1:0] istat_next(input logic [DW-1:0] cur,
                                               input logic [DW-1:0] set,
                                               input logic [DW-1:0] clr,
                                               input logic          wipe);
    if (wipe) return '0;
    return set | (cur & ~clr);
  endfunction

  function automatic logic [DW-1:0] line_word(input logic vbus, input logic [1:0] conn);
    return {5'b00000, vbus, conn};
  endfunction
endpackage

// File: rtl/usbd_evt_capture.sv
`timescale 1ns/1ps
module usbd_evt_capture
  import usbd_regs_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wipe_i,
  input  logic [DW-1:0] clr_i,
  input  logic          txn_done_i,
  input  logic          bus_reset_i,
  input  logic          vbus_i,
  input  logic [1:0]    conn_i,
  output logic [DW-1:0] status_o,
  output logic [DW-1:0] line_o
);
  logic          vbus_q;
  logic [1:0]    conn_q;
  logic [DW-1:0] status_q;
  logic [DW-1:0] set_vec;
  logic [DW-1:0] clr_only;
  logic          vbus_chg;
  logic          conn_chg;

  assign vbus_chg = vbus_i ^ vbus_q;
  assign conn_chg = (conn_i != conn_q);

  always_comb begin
    set_vec           = '0;
    set_vec[BIT_DONE] = txn_done_i;
    set_vec[BIT_CONN] = bus_reset_i | conn_chg;
    set_vec[BIT_VBUS] = vbus_chg;
  end

  assign clr_only = clr_i & ~set_vec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vbus_q   <= 1'b0;
      conn_q   <= 2'b00;
      status_q <= '0;
    end else begin
      vbus_q   <= vbus_i;
      conn_q   <= conn_i;
      status_q <= istat_next(status_q, set_vec, clr_i, wipe_i);
    end
  end

  assign status_o = status_q;
  assign line_o   = line_word(vbus_q, conn_q);

  AST_EVENT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wipe_i && set_vec != '0) |=> ((status_q & $past(set_vec)) == $past(set_vec))); // R8
  AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wipe_i && clr_only != '0) |=> ((status_q & $past(clr_only)) == '0)); // R7
endmodule

// File: rtl/usbd_ep_slot.sv
`timescale 1ns/1ps
module usbd_ep_slot (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wipe_i,
  input  logic       wr_i,
  input  logic [1:0] wdata_i,
  input  logic       done_hit_i,
  output logic       en_o,
  output logic       rdy_o
);
  logic en_q;
  logic rdy_q;

  // Priority: wipe, then the software write, then the hardware ready clear.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      rdy_q <= 1'b0;
    end else if (wipe_i) begin
      en_q  <= 1'b0;
      rdy_q <= 1'b0;
    end else if (wr_i) begin
      en_q  <= wdata_i[0];
      rdy_q <= wdata_i[1];
    end else if (done_hit_i) begin
      rdy_q <= 1'b0;
    end
  end

  assign en_o  = en_q;
  assign rdy_o = rdy_q;

  AST_READY_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_hit_i && !wr_i && !wipe_i) |=> !rdy_q); // R5
  AST_ENABLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_hit_i && !wr_i && !wipe_i) |=> $stable(en_q)); // R5
  AST_ARM_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wdata_i[1] && !wipe_i) |=> rdy_q); // R12
endmodule

// File: rtl/usbd_regbank.sv
`timescale 1ns/1ps
module usbd_regbank
  import usbd_regs_pkg::*;
#(
  parameter int NUM_EP = 4,
  parameter int ADR_W  = 4,
  localparam int EP_W  = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cyc_i,
  input  logic              stb_i,
  input  logic              we_i,
  input  logic [ADR_W-1:0]  adr_i,
  input  logic [DW-1:0]     dat_i,
  output logic [DW-1:0]     dat_o,
  output logic              ack_o,
  input  logic              txn_done_i,
  input  logic [EP_W-1:0]   txn_ep_i,
  input  logic              bus_reset_i,
  input  logic              vbus_i,
  input  logic [1:0]        conn_state_i,
  output logic [NUM_EP-1:0] ep_enable_o,
  output logic [NUM_EP-1:0] ep_ready_o,
  output logic [DW-1:0]     dev_addr_o,
  output logic [DW-1:0]     dev_ctrl_o,
  output logic              host_mode_o,
  output logic              irq_o
);
  logic          access;
  logic          wr_en;
  logic          rd_en;
  logic          wipe;
  logic [1:0]    glob_q;
  logic [DW-1:0] devctl_q;
  logic [DW-1:0] devadr_q;
  logic [DW-1:0] mask_q;
  logic [DW-1:0] clr_vec;
  logic [DW-1:0] status;
  logic [DW-1:0] line;
  logic [DW-1:0] rdata;

  assign access = cyc_i & stb_i;
  assign wr_en  = access & we_i;
  assign rd_en  = access & ~we_i;
  assign ack_o  = access;
  assign wipe   = glob_q[GLB_SOFT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      glob_q   <= '0;
      devctl_q <= '0;
      devadr_q <= '0;
      mask_q   <= MASK_RESET;
    end else if (wipe) begin
      glob_q   <= '0;
      devctl_q <= '0;
      devadr_q <= '0;
      mask_q   <= MASK_RESET;
    end else if (wr_en) begin
      if (adr_i == ADR_W'(OFS_GLOBAL)) glob_q   <= dat_i[1:0];
      if (adr_i == ADR_W'(OFS_DEVCTL)) devctl_q <= dat_i;
      if (adr_i == ADR_W'(OFS_DEVADR)) devadr_q <= dat_i;
      if (adr_i == ADR_W'(OFS_IMASK))  mask_q   <= dat_i;
    end
  end

  assign clr_vec = (wr_en && adr_i == ADR_W'(OFS_ISTAT)) ? dat_i : '0;

  usbd_evt_capture u_evt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wipe_i      (wipe),
    .clr_i       (clr_vec),
    .txn_done_i  (txn_done_i),
    .bus_reset_i (bus_reset_i),
    .vbus_i      (vbus_i),
    .conn_i      (conn_state_i),
    .status_o    (status),
    .line_o      (line)
  );

  for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
    logic ep_wr;
    logic ep_hit;
    assign ep_wr  = wr_en && (adr_i == ADR_W'(OFS_EP0 + g));
    assign ep_hit = txn_done_i && (txn_ep_i == EP_W'(g));
    usbd_ep_slot u_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wipe_i     (wipe),
      .wr_i       (ep_wr),
      .wdata_i    (dat_i[1:0]),
      .done_hit_i (ep_hit),
      .en_o       (ep_enable_o[g]),
      .rdy_o      (ep_ready_o[g])
    );
  end

  always_comb begin
    rdata = '0;
    case (adr_i)
      ADR_W'(OFS_GLOBAL): rdata = {6'b000000, glob_q};
      ADR_W'(OFS_DEVCTL): rdata = devctl_q;
      ADR_W'(OFS_DEVADR): rdata = devadr_q;
      ADR_W'(OFS_ISTAT):  rdata = status;
      ADR_W'(OFS_IMASK):  rdata = mask_q;
      ADR_W'(OFS_LINE):   rdata = line;
      default:            rdata = '0;
    endcase
    for (int i = 0; i < NUM_EP; i++) begin
      if (adr_i == ADR_W'(OFS_EP0 + i))
        rdata = {6'b000000, ep_ready_o[i], ep_enable_o[i]};
    end
  end

  assign dat_o       = rd_en ? rdata : '0;
  assign dev_addr_o  = devadr_q;
  assign dev_ctrl_o  = devctl_q;
  assign host_mode_o = glob_q[GLB_ROLE];
  assign irq_o       = |(status & mask_q);

  AST_SOFT_SELF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wipe |=> (glob_q == 2'b00 && devctl_q == '0 && mask_q == MASK_RESET)); // R3
  AST_IRQ_QUIET_AFTER_WIPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wipe |=> !irq_o); // R3
  AST_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && !wipe && adr_i == ADR_W'(OFS_DEVADR)) |=> (dev_addr_o == $past(dat_i))); // R11
endmodule

// File: tb/usbd_regbank_test.sv
`timescale 1ns/1ps
module usbd_regbank_test;
  localparam int NEP  = 4;
  localparam int AW   = 4;
  localparam int EW   = 2;
  localparam time TCK = 20ns;

  localparam logic [AW-1:0] A_GLB = 4'd0, A_DCT = 4'd1, A_DAD = 4'd2,
                            A_IST = 4'd3, A_IMK = 4'd4, A_LIN = 4'd5, A_EP0 = 4'd8;
  localparam logic [7:0] S_DONE = 8'h01, S_CONN = 8'h04, S_VBUS = 8'h20;

  localparam int K_BUS = 0, K_IRQ = 1, K_RDY = 2, K_EN = 3, K_ADR = 4, K_HOST = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc = 1'b0, stb = 1'b0, we = 1'b0;
  logic [AW-1:0] adr = '0;
  logic [7:0] wdat = '0;
  logic [7:0] rdat;
  logic ack;
  logic done = 1'b0;
  logic [EW-1:0] dep = '0;
  logic breset = 1'b0;
  logic vbus = 1'b0;
  logic [1:0] conn = 2'b00;
  logic [NEP-1:0] ep_en, ep_rdy;
  logic [7:0] daddr, dctl;
  logic host, irq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct {
    int         kind;
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sb[$];
  event smp_ev;

  always #(TCK/2) clk = ~clk;

  usbd_regbank #(.NUM_EP(NEP), .ADR_W(AW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cyc_i(cyc), .stb_i(stb), .we_i(we),
    .adr_i(adr), .dat_i(wdat), .dat_o(rdat), .ack_o(ack),
    .txn_done_i(done), .txn_ep_i(dep), .bus_reset_i(breset),
    .vbus_i(vbus), .conn_state_i(conn),
    .ep_enable_o(ep_en), .ep_ready_o(ep_rdy), .dev_addr_o(daddr),
    .dev_ctrl_o(dctl), .host_mode_o(host), .irq_o(irq)
  );

  function automatic logic [7:0] line_exp(input logic v, input logic [1:0] c);
    return (v ? 8'h04 : 8'h00) + {6'b0, c};
  endfunction

  // Monitor: pops one expected item per sample event and compares.
  always begin
    item_t it;
    logic [7:0] act;
    @(smp_ev);
    if (sb.size() == 0) begin
      checks++; errors++;
      $display("FAIL scoreboard: sample with no expected item");
    end else begin
      it = sb.pop_front();
      case (it.kind)
        K_BUS:   act = rdat;
        K_IRQ:   act = {7'b0, irq};
        K_RDY:   act = {4'b0, ep_rdy};
        K_EN:    act = {4'b0, ep_en};
        K_ADR:   act = daddr;
        default: act = {7'b0, host};
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s kind %0d actual %02h expected %02h", it.tag, it.kind, act, it.exp);
      end
      if (it.kind == K_BUS) begin
        checks++;
        if (ack !== 1'b1) begin
          errors++;
          $display("FAIL R11 ack actual %b expected 1", ack);
        end
      end
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); cyc = 1; stb = 1; we = 1; adr = a; wdat = d;
    @(negedge clk); cyc = 0; stb = 0; we = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [7:0] e, input string tag);
    @(negedge clk); cyc = 1; stb = 1; we = 0; adr = a;
    sb.push_back('{K_BUS, e, tag});
    #5 -> smp_ev;
    @(negedge clk); cyc = 0; stb = 0;
  endtask

  task automatic probe(input int k, input logic [7:0] e, input string tag);
    @(negedge clk);
    sb.push_back('{k, e, tag});
    #5 -> smp_ev;
  endtask

  task automatic pulse_done(input logic [EW-1:0] ep);
    @(negedge clk); done = 1; dep = ep;
    @(negedge clk); done = 0;
  endtask

  task automatic finish_run();
    #1;
    if (sb.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard: %0d items left, expected 0", sb.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(TCK * 100000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(A_GLB, 8'h00, "R1 global");
    rd(A_IST, 8'h00, "R1 status");
    rd(A_IMK, 8'hFF, "R1 mask");
    probe(K_IRQ, 8'h00, "R1 irq");
    probe(K_RDY, 8'h00, "R1 ready");

    // R2 read/write registers
    wr(A_DCT, 8'h70); rd(A_DCT, 8'h70, "R2 devctl");
    wr(A_DAD, 8'h5A); probe(K_ADR, 8'h5A, "R2 addr out");
    wr(A_GLB, 8'h01); rd(A_GLB, 8'h01, "R2 role");
    probe(K_HOST, 8'h01, "R2 host out");
    wr(A_IMK, 8'h21); rd(A_IMK, 8'h21, "R2 mask");

    // R4 arm endpoints 1 and 2
    wr(A_EP0 + 4'd1, 8'h03); wr(A_EP0 + 4'd2, 8'h03);
    rd(A_EP0 + 4'd1, 8'h03, "R4 ep1");
    probe(K_RDY, 8'h06, "R4 ready");
    probe(K_EN,  8'h06, "R4 enable");

    // R5 / R6 transaction done on endpoint 1
    pulse_done(2'd1);
    rd(A_EP0 + 4'd1, 8'h01, "R5 ep1");
    probe(K_RDY, 8'h04, "R5 ready others kept");
    probe(K_EN,  8'h06, "R5 enable kept");
    rd(A_IST, S_DONE, "R6 done bit");
    probe(K_IRQ, 8'h01, "R10 irq masked-in");

    // R7 clear
    wr(A_IST, S_DONE); rd(A_IST, 8'h00, "R7 cleared");
    probe(K_IRQ, 8'h00, "R7 irq low");

    // R6 / R9 level changes
    @(negedge clk); vbus = 1;
    rd(A_IST, S_VBUS, "R6 vbus change");
    rd(A_LIN, line_exp(1'b1, 2'd0), "R9 vbus only");
    @(negedge clk); conn = 2'd2;
    rd(A_IST, S_VBUS | S_CONN, "R6 connect change");
    rd(A_LIN, line_exp(1'b1, 2'd2), "R9 full speed");
    wr(A_IST, S_VBUS | S_CONN); rd(A_IST, 8'h00, "R7 write back");

    // R10 masking with a bus reset event
    @(negedge clk); breset = 1; @(negedge clk); breset = 0;
    rd(A_IST, S_CONN, "R6 bus reset");
    probe(K_IRQ, 8'h00, "R10 masked out");
    wr(A_IMK, 8'h04); probe(K_IRQ, 8'h01, "R10 unmasked");
    wr(A_IST, 8'h00); rd(A_IST, S_CONN, "R7 zeros keep");

    // R8 set and clear in one cycle
    @(negedge clk); cyc = 1; stb = 1; we = 1; adr = A_IST; wdat = S_CONN | S_DONE;
    done = 1; dep = 2'd2;
    @(negedge clk); cyc = 0; stb = 0; we = 0; done = 0;
    rd(A_IST, S_DONE, "R8 set wins");
    probe(K_RDY, 8'h00, "R5 ep2 ready cleared");
    wr(A_IST, S_DONE); rd(A_IST, 8'h00, "R7 clear done");

    // R12 arm and done in one cycle
    @(negedge clk); cyc = 1; stb = 1; we = 1; adr = A_EP0 + 4'd3; wdat = 8'h03;
    done = 1; dep = 2'd3;
    @(negedge clk); cyc = 0; stb = 0; we = 0; done = 0;
    rd(A_EP0 + 4'd3, 8'h03, "R12 write wins");
    probe(K_RDY, 8'h08, "R12 ready");

    // R3 soft reset
    wr(A_GLB, 8'h02);
    rd(A_GLB, 8'h00, "R3 global self-clear");
    rd(A_DCT, 8'h00, "R3 devctl");
    rd(A_IMK, 8'hFF, "R3 mask restored");
    rd(A_IST, 8'h00, "R3 status");
    probe(K_ADR, 8'h00, "R3 addr");
    probe(K_EN, 8'h00, "R3 enable");
    probe(K_RDY, 8'h00, "R3 ready");
    probe(K_HOST, 8'h00, "R3 role");

    // R9 disconnect
    @(negedge clk); conn = 2'd0;
    rd(A_IST, S_CONN, "R6 disconnect");
    rd(A_LIN, line_exp(1'b1, 2'd0), "R9 disconnect");
    probe(K_IRQ, 8'h01, "R10 irq after wipe mask");

    finished = 1'b1;
    finish_run();
  end
endmodule